// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the program counter of a small 8-bit processor with a 16-bit address space. It computes the PC for the next instruction after each instruction the decoder issues. The decoder presents one instruction per `step_i` pulse, together with its class, its operand byte and the branch condition. The class is one of four:

- a one-byte operand-free instruction;
- a two-byte instruction that carries an operand;
- a two-byte conditional relative branch;
- a one-byte vector call.

Branches add a sign-extended offset to the address just past the branch. The base used is that address, not the address of the branch opcode.

A vector call looks up its target in a table of sixteen-bit entries placed at the top of memory. Each entry holds the high byte first. The block fetches the two bytes through a synchronous byte-read port, one byte per cycle, and holds `busy_o` high until the new PC is loaded. It also hands the return address to the stack logic and pulses a push strobe for it. Decoding, the stack itself and arithmetic on data are handled elsewhere.

Top module: `pc_next_unit`

## Requirements
- R1: A synchronous reset loads `pc_o` with `RESET_PC` (default 0x8000), clears `busy_o` and `ret_push_o`, and leaves `mem_rd_o` low.
- R2: A step of class 2'b00 (operand-free) sets `pc_o` to the old PC plus 1 on the clock edge that samples the step.
- R3: A step of class 2'b01 (instruction with one operand byte) sets `pc_o` to the old PC plus 2 on the sampling edge.
- R4: A step of class 2'b10 (relative branch) with `cond_i` high sets `pc_o` to the old PC plus 2, plus the operand read as a signed 8-bit value. For example, a branch at 0x9ABA with operand 0xFE lands on 0x9ABA.
- R5: Relative branch reach spans 128 bytes below the base (operand 0x80) to 127 bytes above it (operand 0x7F).
- R6: A relative branch with `cond_i` low sets `pc_o` to the old PC plus 2.
- R7: All PC arithmetic wraps modulo 65536.
- R8: A step of class 2'b11 (vector call) uses `opnd_i[2:0]` as the vector number n. It reads address 0xFFC0+2n in the cycle of the step and the next address in the following cycle. The first byte returned becomes the high byte of the new PC and the second byte becomes the low byte. Read data arrives the cycle after its request.
- R9: After a vector-call step, `busy_o` is high for exactly two cycles. The new PC appears on `pc_o` in the cycle `busy_o` returns low.
- R10: During a vector fetch, `ret_addr_o` holds the calling PC plus 1. `ret_push_o` is high only in the second busy cycle.
- R11: `mem_rd_o` is asserted only for vector-table reads.
- R12: `step_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | An instruction is issued this cycle |
| cls_i | input | 2 | Instruction class (00 inherent, 01 operand, 10 relative branch, 11 vector call) |
| opnd_i | input | 8 | Operand byte, or vector number in bits 2:0 |
| cond_i | input | 1 | Branch condition holds |
| mem_rd_o | output | 1 | Byte read request |
| mem_addr_o | output | 16 | Read address |
| mem_data_i | input | 8 | Read data, valid the cycle after the request |
| pc_o | output | 16 | Current program counter |
| busy_o | output | 1 | Vector fetch in progress |
| ret_addr_o | output | 16 | Return address to push |
| ret_push_o | output | 1 | Push strobe for the return address |

## Verification
The hard cases are relative branches near the top of the address space and wrapping of the PC itself, because the PC can only be moved through the block's own instructions. The bench first uses vector calls to jump to chosen addresses such as 0xFFFF and 0xFFF0, with table contents supplied by its memory model. From there it issues steps that must wrap. It also issues steps during the busy window of a vector call to show they are dropped.

// File: rtl/pcn_pkg.sv
package pcn_pkg;
    localparam int DW = 8;
    localparam int AW = 2 * DW;

    typedef enum logic [1:0] {
        CLS_INH  = 2'b00,
        CLS_OPND = 2'b01,
        CLS_REL  = 2'b10,
        CLS_VEC  = 2'b11
    } instr_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RD_LO = 2'b01,
        ST_LOAD = 2'b10
    } fetch_st_e;

    typedef struct packed {
        fetch_st_e       fsm;
        logic [AW-1:0]   pc;
        logic [AW-1:0]   vaddr;
        logic [DW-1:0]   hi;
        logic [AW-1:0]   ret;
    } pcn_state_t;
endpackage

// File: rtl/pcn_rel_target.sv
module pcn_rel_target
    import pcn_pkg::*;
(
    input  logic [AW-1:0] pc_i,
    input  logic [DW-1:0] ofs_i,
    output logic [AW-1:0] inc1_o,
    output logic [AW-1:0] inc2_o,
    output logic [AW-1:0] tgt_o
);
    logic [AW-1:0] ofs_ext;

    always_comb begin
        ofs_ext = {{(AW-DW){ofs_i[DW-1]}}, ofs_i};
        inc1_o  = pc_i + AW'(1);
        inc2_o  = pc_i + AW'(2);
        tgt_o   = inc2_o + ofs_ext;
    end
endmodule

// File: rtl/pcn_vec_addr.sv
module pcn_vec_addr
    import pcn_pkg::*;
#(
    parameter int            IDX_W    = 3,
    parameter logic [AW-1:0] TBL_BASE = 16'hFFC0
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [AW-1:0]    addr_o
);
    localparam int SHW = IDX_W + 1;

    always_comb begin
        addr_o = TBL_BASE + AW'({idx_i, 1'b0});
    end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
    import pcn_pkg::*;
#(
    parameter int            IDX_W    = 3,
    parameter logic [15:0]   TBL_BASE = 16'hFFC0,
    parameter logic [15:0]   RESET_PC = 16'h8000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step_i,
    input  logic [1:0]  cls_i,
    input  logic [7:0]  opnd_i,
    input  logic        cond_i,
    output logic        mem_rd_o,
    output logic [15:0] mem_addr_o,
    input  logic [7:0]  mem_data_i,
    output logic [15:0] pc_o,
    output logic        busy_o,
    output logic [15:0] ret_addr_o,
    output logic        ret_push_o
);
    pcn_state_t    st_d, st_q;
    logic [AW-1:0] pc_inc1, pc_inc2, rel_tgt, vec_addr;
    instr_cls_e    cls;

    assign cls = instr_cls_e'(cls_i);

    pcn_rel_target u_rel (
        .pc_i   (st_q.pc),
        .ofs_i  (opnd_i),
        .inc1_o (pc_inc1),
        .inc2_o (pc_inc2),
        .tgt_o  (rel_tgt)
    );

    pcn_vec_addr #(
        .IDX_W    (IDX_W),
        .TBL_BASE (TBL_BASE)
    ) u_vaddr (
        .idx_i  (opnd_i[IDX_W-1:0]),
        .addr_o (vec_addr)
    );

    always_comb begin
        st_d       = st_q;
        mem_rd_o   = 1'b0;
        mem_addr_o = st_q.vaddr;
        ret_push_o = 1'b0;
        unique case (st_q.fsm)
            ST_IDLE: begin
                if (step_i) begin
                    unique case (cls)
                        CLS_INH:  st_d.pc = pc_inc1;
                        CLS_OPND: st_d.pc = pc_inc2;
                        CLS_REL:  st_d.pc = cond_i ? rel_tgt : pc_inc2;
                        CLS_VEC: begin
                            mem_rd_o   = 1'b1;
                            mem_addr_o = vec_addr;
                            st_d.vaddr = vec_addr;
                            st_d.ret   = pc_inc1;
                            st_d.fsm   = ST_RD_LO;
                        end
                        default: st_d.pc = pc_inc1;
                    endcase
                end
            end
            ST_RD_LO: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = st_q.vaddr + AW'(1);
                st_d.hi    = mem_data_i;
                st_d.fsm   = ST_LOAD;
            end
            ST_LOAD: begin
                st_d.pc    = {st_q.hi, mem_data_i};
                ret_push_o = 1'b1;
                st_d.fsm   = ST_IDLE;
            end
            default: st_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.fsm   <= ST_IDLE;
            st_q.pc    <= RESET_PC;
            st_q.vaddr <= TBL_BASE;
            st_q.hi    <= '0;
            st_q.ret   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o       = st_q.pc;
    assign busy_o     = (st_q.fsm != ST_IDLE);
    assign ret_addr_o = st_q.ret;
endmodule

// File: rtl/pcn_chk.sv
module pcn_chk (
    input logic        clk,
    input logic        rst,
    input logic        step_i,
    input logic [1:0]  cls_i,
    input logic        mem_rd_o,
    input logic [15:0] mem_addr_o,
    input logic [15:0] pc_o,
    input logic        busy_o,
    input logic        ret_push_o
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy_o && !ret_push_o && !mem_rd_o));

    // R2
    inh_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && !busy_o && cls_i == 2'b00) |=> (pc_o == $past(pc_o) + 16'd1));

    // R8
    second_read_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && !busy_o) |=> (mem_rd_o && mem_addr_o == $past(mem_addr_o) + 16'd1));

    // R9
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |=> (busy_o ##1 !busy_o));

    // R10
    push_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        ret_push_o |-> (busy_o && !mem_rd_o));

    // R11
    rd_only_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && !busy_o) |-> (step_i && cls_i == 2'b11));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !ret_push_o) |=> $stable(pc_o));
endmodule

bind pc_next_unit pcn_chk u_pcn_chk (
    .clk        (clk),
    .rst        (rst),
    .step_i     (step_i),
    .cls_i      (cls_i),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o),
    .pc_o       (pc_o),
    .busy_o     (busy_o),
    .ret_push_o (ret_push_o)
);

// File: tb/pc_next_unit_tb_top.sv
module pc_next_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_i = 1'b0;
    logic [1:0]  cls_i = 2'b00;
    logic [7:0]  opnd_i = 8'h00;
    logic        cond_i = 1'b0;
    logic        mem_rd_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_data_i;
    logic [15:0] pc_o;
    logic        busy_o;
    logic [15:0] ret_addr_o;
    logic        ret_push_o;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] vtbl [16];
    int rd_count = 0;

    always #2 clk = ~clk;

    pc_next_unit dut_i (
        .clk(clk), .rst(rst), .step_i(step_i), .cls_i(cls_i), .opnd_i(opnd_i),
        .cond_i(cond_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
        .mem_data_i(mem_data_i), .pc_o(pc_o), .busy_o(busy_o),
        .ret_addr_o(ret_addr_o), .ret_push_o(ret_push_o)
    );

    always_ff @(posedge clk) begin
        if (mem_rd_o) begin
            mem_data_i <= (mem_addr_o[15:4] == 12'hFFC) ? vtbl[mem_addr_o[3:0]] : 8'h00;
            rd_count   <= rd_count + 1;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // issue one step at a negedge; returns at the next negedge
    task automatic issue(input logic [1:0] c, input logic [7:0] o, input logic cd);
        @(negedge clk);
        step_i = 1'b1; cls_i = c; opnd_i = o; cond_i = cd;
        @(negedge clk);
        step_i = 1'b0;
    endtask

    // vector call with full timing checks; leaves pc at target
    task automatic vcall(input logic [2:0] n);
        logic [15:0] start, tgt;
        start = pc_o;
        tgt = {vtbl[{n, 1'b0}], vtbl[{n, 1'b1}]};
        @(negedge clk);
        step_i = 1'b1; cls_i = 2'b11; opnd_i = {5'b0, n}; cond_i = 1'b0;
        #1;
        chk("R8 first read req", {15'b0, mem_rd_o}, 16'd1);
        chk("R8 first read addr", mem_addr_o, 16'hFFC0 + {12'b0, n, 1'b0});
        @(negedge clk);
        step_i = 1'b0;
        chk("R9 busy cycle 1", {15'b0, busy_o}, 16'd1);
        chk("R8 second read addr", mem_addr_o, 16'hFFC1 + {12'b0, n, 1'b0});
        chk("R10 ret addr", ret_addr_o, start + 16'd1);
        chk("R10 no push yet", {15'b0, ret_push_o}, 16'd0);
        @(negedge clk);
        chk("R9 busy cycle 2", {15'b0, busy_o}, 16'd1);
        chk("R10 push strobe", {15'b0, ret_push_o}, 16'd1);
        chk("R11 no read in cycle 2", {15'b0, mem_rd_o}, 16'd0);
        @(negedge clk);
        chk("R9 busy low", {15'b0, busy_o}, 16'd0);
        chk("R8 target", pc_o, tgt);
    endtask

    task automatic t_reset();
        chk("R1 pc reset", pc_o, 16'h8000);
        chk("R1 busy reset", {15'b0, busy_o}, 16'd0);
        chk("R1 no read", {15'b0, mem_rd_o}, 16'd0);
        chk("R1 no push", {15'b0, ret_push_o}, 16'd0);
    endtask

    task automatic t_seq();
        logic [15:0] p;
        p = pc_o;
        issue(2'b00, 8'h00, 1'b0);
        chk("R2 inherent", pc_o, p + 16'd1);
        issue(2'b01, 8'h55, 1'b1);
        chk("R3 operand instr", pc_o, p + 16'd3);
        chk("R11 no read on seq", {15'b0, mem_rd_o}, 16'd0);
        chk("R11 read count", 16'(rd_count), 16'd0);
    endtask

    task automatic t_rel();
        vcall(3'd1);
        issue(2'b10, 8'hFE, 1'b1);
        chk("R4 tight loop", pc_o, 16'h9ABA);
        issue(2'b10, 8'h10, 1'b1);
        chk("R4 forward", pc_o, 16'h9ACC);
        issue(2'b10, 8'h10, 1'b0);
        chk("R6 not taken", pc_o, 16'h9ACE);
        issue(2'b10, 8'h80, 1'b1);
        chk("R5 min reach", pc_o, 16'h9AD0 - 16'd128);
        issue(2'b10, 8'h7F, 1'b1);
        chk("R5 max reach", pc_o, 16'h9A52 + 16'd127);
    endtask

    task automatic t_vec5();
        logic [15:0] p;
        p = pc_o;
        vcall(3'd5);
        chk("R8 vector 5", pc_o, 16'hFEDC);
        vcall(3'd7);
        vcall(3'd0);
    endtask

    task automatic t_wrap();
        vcall(3'd2);
        issue(2'b00, 8'h00, 1'b0);
        chk("R7 inherent wrap", pc_o, 16'h0000);
        vcall(3'd3);
        issue(2'b10, 8'h7F, 1'b1);
        chk("R7 branch wrap", pc_o, 16'h0071);
        issue(2'b10, 8'h80, 1'b1);
        chk("R7 backward wrap", pc_o, 16'hFFF3);
    endtask

    task automatic t_ignore();
        vcall(3'd4);
        @(negedge clk);
        step_i = 1'b1; cls_i = 2'b11; opnd_i = 8'h06; cond_i = 1'b0;
        @(negedge clk);
        step_i = 1'b1; cls_i = 2'b00;
        chk("R12 busy during call", {15'b0, busy_o}, 16'd1);
        @(negedge clk);
        step_i = 1'b1; cls_i = 2'b01;
        chk("R12 pc held", pc_o, 16'h1234);
        @(negedge clk);
        step_i = 1'b0;
        chk("R12 steps dropped", pc_o, {vtbl[12], vtbl[13]});
        @(negedge clk);
        chk("R12 no later effect", pc_o, {vtbl[12], vtbl[13]});
    endtask

    initial begin
        vtbl[0]  = 8'h40; vtbl[1]  = 8'h00;
        vtbl[2]  = 8'h9A; vtbl[3]  = 8'hBA;
        vtbl[4]  = 8'hFF; vtbl[5]  = 8'hFF;
        vtbl[6]  = 8'hFF; vtbl[7]  = 8'hF0;
        vtbl[8]  = 8'h12; vtbl[9]  = 8'h34;
        vtbl[10] = 8'hFE; vtbl[11] = 8'hDC;
        vtbl[12] = 8'hC3; vtbl[13] = 8'h5A;
        vtbl[14] = 8'h01; vtbl[15] = 8'h80;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_seq();
        t_rel();
        t_vec5();
        t_wrap();
        t_ignore();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule